// File: doc/BRIEF.md
# Transmit Descriptor Chain Engine

This block is the transmit side of a simple Ethernet MAC. It owns a small word-addressed descriptor store. The host fills that store and later reads it back. When the host issues a poll, the engine reads a four-word descriptor at its current descriptor pointer.

- **Descriptor layout.** Word 0 is status and word 1 is control. Word 2 is the buffer byte address and word 3 is the branch, the word address of the next descriptor.
- **Byte output.** The engine streams the buffer bytes, one per cycle, on a byte output with a last marker. It then writes a status word back into word 0, with the ownership bit cleared.
- **Frames over two buffers.** A frame may occupy one descriptor, or a start buffer chained to an end buffer.
- **Errors.** Line errors such as collisions, underflow and carrier loss arrive as inputs. They are sampled when the status is written back. An abort, an underflow or a malformed descriptor switches the transmit process off. It stays off until the host rewrites the pointer and polls again.

Buffer bytes come from an external byte-addressed read port, which returns data in the same cycle. The block has no frame check sequence logic, no collision logic and no PHY interface. It only passes through a per-frame flag that tells the downstream stage to skip the checksum.

Top module: `txd_engine`

## Requirements
- R1: After reset the transmit process is off (tx_on_o=0), busy_o=0, and no byte, completion or interrupt pulse is driven while idle.
- R2: A poll_i sampled while idle sets tx_on_o and fetches the descriptor at the current pointer in the next cycle. The first buffer byte appears one cycle after the fetch. Byte n of a buffer comes from buffer address (word 2 + n). The byte count is control bits 10:0.
- R3: A fetched descriptor whose status bit 31 (owned) is clear produces no byte and no write-back. The engine returns to idle one cycle later with tx_on_o still set.
- R4: A descriptor with both start (control bit 21) and end (control bit 22) sends its bytes as one frame. tx_last_o is set only on the final byte, and status is then written back with bit 31 clear.
- R5: A start descriptor without end but with the chain flag (control bit 15) and a nonzero branch (word 3) continues at the branch descriptor. tx_last_o is set only on the end buffer's final byte.
- R6: The written status holds the following fields, with all inputs sampled in the write-back cycle:
  - the collision count in bits 3:0, and bit 4 when that count is nonzero;
  - the abort in bits 8 and 15;
  - late collision in bit 9;
  - carrier loss in bit 10;
  - underflow in bit 11;
  - system error in bit 13.
- R7: After a write-back with abort (bit 8), underflow (bit 11) or invalid (bit 12), tx_on_o and busy_o are 0 from the next cycle and the pointer is unchanged. A later poll re-arms the engine at the pointer the host has set with cur_we_i.
- R8: A descriptor without the start flag, met outside a frame, sends no bytes. Its status is written as bit 12 alone (0x00001000), and the engine halts as in R7.
- R9: eop_done_o pulses in the write-back cycle of an end descriptor. txok_irq_o pulses there when status bits 15:8 are all clear. txok_irq_o also pulses in the write-back cycle of any descriptor with control bit 23 set, whatever its status.
- R10: udf_irq_o pulses in the write-back cycle whose status has the underflow bit 11 set.
- R11: A zero branch, or a branch to a descriptor that is not owned, returns the engine to idle with tx_on_o kept. In the second case the pointer stays at the branch target, so the next poll resumes there.
- R12: A poll while busy has no effect. Control bit 16 of the start descriptor is presented on tx_nocrc_o with every byte of that frame.
- R13: A descriptor with a byte count of zero sends no byte and is written back in the cycle after its fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host write strobe to descriptor store |
| host_addr_i | input | AW (6) | Host word address, shared by read and write |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Descriptor store word at host_addr_i |
| cur_we_i | input | 1 | Load current descriptor pointer (honoured when idle) |
| cur_addr_i | input | AW (6) | New current descriptor pointer |
| poll_i | input | 1 | Poll demand; arms and starts fetching when idle |
| err_abort_i | input | 1 | Excessive-collision abort |
| err_underflow_i | input | 1 | Transmit FIFO underflow |
| err_late_i | input | 1 | Late collision |
| err_carrier_i | input | 1 | Carrier lost |
| err_sys_i | input | 1 | System error |
| col_cnt_i | input | 4 | Collision retry count |
| buf_addr_o | output | BUF_AW (16) | Buffer byte read address |
| buf_data_i | input | 8 | Buffer byte at buf_addr_o (same cycle) |
| tx_valid_o | output | 1 | Byte valid |
| tx_data_o | output | 8 | Byte data |
| tx_last_o | output | 1 | Final byte of frame |
| tx_nocrc_o | output | 1 | Frame must not get a checksum appended |
| tx_on_o | output | 1 | Transmit process enabled |
| busy_o | output | 1 | Engine fetching, sending or writing back |
| eop_done_o | output | 1 | End-of-frame status written |
| txok_irq_o | output | 1 | Transmit-ok interrupt pulse |
| udf_irq_o | output | 1 | Underflow interrupt pulse |

## Verification
Timing is counted from the clock edge that samples poll_i:

| Cycle after that edge | Event |
|---|---|
| 0 | Descriptor fetch; busy_o and tx_on_o already high |
| 1 to N | Bytes, where N is the byte count |
| N+1 | Write-back, with eop_done_o, txok_irq_o and udf_irq_o |
| N+2 | Next fetch, or idle |

A halting write-back drops tx_on_o one cycle after that write-back cycle. The status word can be read on the host port from the cycle after write-back.

At each poll the bench expands a behavioural model of the descriptor store into a queue holding one expected entry per cycle, following the timing above. At every falling edge it pops one entry and compares it with all outputs, so every latency is checked exactly. Status words are compared against the model store after each run.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int DESC_WORDS = 4;
  localparam int SIZE_W     = 11;
  // control word bit positions
  localparam int CTL_CHAIN  = 15;
  localparam int CTL_NOCRC  = 16;
  localparam int CTL_SOP    = 21;
  localparam int CTL_EOP    = 22;
  localparam int CTL_IRQ    = 23;
  // status word bit positions
  localparam int ST_COLS    = 4;
  localparam int ST_ABORT   = 8;
  localparam int ST_LATE    = 9;
  localparam int ST_CARRIER = 10;
  localparam int ST_UNDER   = 11;
  localparam int ST_INVALID = 12;
  localparam int ST_SYSERR  = 13;
  localparam int ST_EXCESS  = 15;
  localparam int ST_OWN     = 31;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_SEND, S_WB} state_e;

  typedef struct packed {
    logic       abort;
    logic       underflow;
    logic       late;
    logic       carrier;
    logic       syserr;
    logic [3:0] col_cnt;
  } tx_err_t;
endpackage

// File: rtl/txd_desc_ram.sv
module txd_desc_ram import txd_pkg::*; #(
  parameter int WORDS = 64,
  parameter int AW    = $clog2(WORDS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         host_we_i,
  input  logic [AW-1:0]                host_addr_i,
  input  logic [31:0]                  host_wdata_i,
  output logic [31:0]                  host_rdata_o,
  input  logic                         wb_we_i,
  input  logic [AW-1:0]                wb_addr_i,
  input  logic [31:0]                  wb_data_i,
  input  logic [AW-1:0]                rd_base_i,
  output logic [DESC_WORDS-1:0][31:0]  rd_words_o
);
  logic [31:0] mem_q [WORDS];

  // engine write-back wins over a same-cycle host write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '0;
    end else if (wb_we_i) begin
      mem_q[wb_addr_i] <= wb_data_i;
    end else if (host_we_i) begin
      mem_q[host_addr_i] <= host_wdata_i;
    end
  end

  assign host_rdata_o = mem_q[host_addr_i];

  for (genvar k = 0; k < DESC_WORDS; k++) begin : g_rd
    logic [AW-1:0] idx;
    assign idx           = rd_base_i + AW'(k);
    assign rd_words_o[k] = mem_q[idx];
  end
endmodule

// File: rtl/txd_status_fmt.sv
module txd_status_fmt import txd_pkg::*; (
  input  tx_err_t     err_i,
  input  logic        invalid_i,
  output logic [31:0] status_o
);
  always_comb begin
    status_o = '0;
    if (invalid_i) begin
      status_o[ST_INVALID] = 1'b1;
    end else begin
      status_o[3:0]        = err_i.col_cnt;
      status_o[ST_COLS]    = |err_i.col_cnt;
      status_o[ST_ABORT]   = err_i.abort;
      status_o[ST_EXCESS]  = err_i.abort;
      status_o[ST_LATE]    = err_i.late;
      status_o[ST_CARRIER] = err_i.carrier;
      status_o[ST_UNDER]   = err_i.underflow;
      status_o[ST_SYSERR]  = err_i.syserr;
    end
  end
endmodule

// File: rtl/txd_engine.sv
module txd_engine import txd_pkg::*; #(
  parameter int WORDS  = 64,
  parameter int BUF_AW = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      host_we_i,
  input  logic [$clog2(WORDS)-1:0]  host_addr_i,
  input  logic [31:0]               host_wdata_i,
  output logic [31:0]               host_rdata_o,
  input  logic                      cur_we_i,
  input  logic [$clog2(WORDS)-1:0]  cur_addr_i,
  input  logic                      poll_i,
  input  logic                      err_abort_i,
  input  logic                      err_underflow_i,
  input  logic                      err_late_i,
  input  logic                      err_carrier_i,
  input  logic                      err_sys_i,
  input  logic [3:0]                col_cnt_i,
  output logic [BUF_AW-1:0]         buf_addr_o,
  input  logic [7:0]                buf_data_i,
  output logic                      tx_valid_o,
  output logic [7:0]                tx_data_o,
  output logic                      tx_last_o,
  output logic                      tx_nocrc_o,
  output logic                      tx_on_o,
  output logic                      busy_o,
  output logic                      eop_done_o,
  output logic                      txok_irq_o,
  output logic                      udf_irq_o
);
  localparam int AW = $clog2(WORDS);

  state_e                      state_q;
  logic [AW-1:0]               cur_q, br_q;
  logic                        tx_on_q, in_pkt_q, inv_q, eop_q, chain_q, irq_q, nocrc_q;
  logic [SIZE_W-1:0]           size_q, cnt_q;
  logic [BUF_AW-1:0]           ba_q;
  logic [DESC_WORDS-1:0][31:0] rd_words;
  logic [31:0]                 wb_word;
  tx_err_t                     err;
  logic                        wb_we, abort_class, any_err, last_byte;
  logic                        f_own, f_sop, f_inv;
  logic [SIZE_W-1:0]           f_size;
  logic                        unused_bits;

  txd_desc_ram #(.WORDS(WORDS), .AW(AW)) u_ram (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .host_we_i   (host_we_i),
    .host_addr_i (host_addr_i),
    .host_wdata_i(host_wdata_i),
    .host_rdata_o(host_rdata_o),
    .wb_we_i     (wb_we),
    .wb_addr_i   (cur_q),
    .wb_data_i   (wb_word),
    .rd_base_i   (cur_q),
    .rd_words_o  (rd_words)
  );

  assign err = '{abort: err_abort_i, underflow: err_underflow_i, late: err_late_i,
                 carrier: err_carrier_i, syserr: err_sys_i, col_cnt: col_cnt_i};

  txd_status_fmt u_fmt (
    .err_i    (err),
    .invalid_i(inv_q),
    .status_o (wb_word)
  );

  assign f_own  = rd_words[0][ST_OWN];
  assign f_sop  = rd_words[1][CTL_SOP];
  assign f_size = rd_words[1][SIZE_W-1:0];
  assign f_inv  = !in_pkt_q && !f_sop;

  assign unused_bits = ^{rd_words[0][30:0], rd_words[1][31:24], rd_words[1][20:17],
                         rd_words[1][14:SIZE_W], rd_words[2][31:BUF_AW], rd_words[3][31:AW]};

  assign wb_we       = (state_q == S_WB);
  assign abort_class = wb_word[ST_ABORT] | wb_word[ST_UNDER] | wb_word[ST_INVALID];
  assign any_err     = |wb_word[15:8];
  assign last_byte   = (cnt_q == size_q - SIZE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      cur_q    <= '0;
      br_q     <= '0;
      tx_on_q  <= 1'b0;
      in_pkt_q <= 1'b0;
      inv_q    <= 1'b0;
      eop_q    <= 1'b0;
      chain_q  <= 1'b0;
      irq_q    <= 1'b0;
      nocrc_q  <= 1'b0;
      size_q   <= '0;
      cnt_q    <= '0;
      ba_q     <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cur_we_i) cur_q <= cur_addr_i;
          if (poll_i) begin
            tx_on_q <= 1'b1;
            state_q <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (!f_own) begin
            state_q <= S_IDLE;
          end else begin
            eop_q   <= rd_words[1][CTL_EOP];
            chain_q <= rd_words[1][CTL_CHAIN];
            irq_q   <= rd_words[1][CTL_IRQ];
            size_q  <= f_size;
            ba_q    <= rd_words[2][BUF_AW-1:0];
            br_q    <= rd_words[3][AW-1:0];
            cnt_q   <= '0;
            inv_q   <= f_inv;
            if (f_sop) nocrc_q <= rd_words[1][CTL_NOCRC];
            state_q <= (f_inv || f_size == '0) ? S_WB : S_SEND;
          end
        end
        S_SEND: begin
          cnt_q <= cnt_q + SIZE_W'(1);
          if (last_byte) state_q <= S_WB;
        end
        S_WB: begin
          if (abort_class) begin
            tx_on_q  <= 1'b0;
            in_pkt_q <= 1'b0;
            state_q  <= S_IDLE;
          end else begin
            in_pkt_q <= !eop_q;
            if ((eop_q || chain_q) && br_q != '0) begin
              cur_q   <= br_q;
              state_q <= S_FETCH;
            end else begin
              state_q <= S_IDLE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != S_IDLE);
  assign tx_on_o    = tx_on_q;
  assign tx_valid_o = (state_q == S_SEND);
  assign tx_data_o  = buf_data_i;
  assign buf_addr_o = ba_q + BUF_AW'(cnt_q);
  assign tx_last_o  = tx_valid_o && eop_q && last_byte;
  assign tx_nocrc_o = tx_valid_o && nocrc_q;
  assign eop_done_o = wb_we && eop_q && !inv_q;
  assign txok_irq_o = wb_we && ((eop_q && !inv_q && !any_err) || irq_q);
  assign udf_irq_o  = wb_we && wb_word[ST_UNDER];

  // R2
  valid_needs_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_on_o);
  // R4
  last_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);
  // R7
  halt_after_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we && abort_class) |=> (!tx_on_o && !busy_o));
  // R12
  arm_only_by_poll_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_on_o) |-> $past(poll_i));
  // R9
  done_then_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_done_o |=> !tx_valid_o);
endmodule

// File: tb/txd_engine_test.sv
module txd_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 64;
  localparam int AW = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic host_we_i = 0, cur_we_i = 0, poll_i = 0;
  logic [AW-1:0] host_addr_i = '0, cur_addr_i = '0;
  logic [31:0] host_wdata_i = '0, host_rdata_o;
  logic err_abort_i = 0, err_underflow_i = 0, err_late_i = 0, err_carrier_i = 0, err_sys_i = 0;
  logic [3:0] col_cnt_i = '0;
  logic [15:0] buf_addr_o;
  logic [7:0] buf_data_i, tx_data_o;
  logic tx_valid_o, tx_last_o, tx_nocrc_o, tx_on_o, busy_o, eop_done_o, txok_irq_o, udf_irq_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  function automatic logic [7:0] fdata(logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
  assign buf_data_i = fdata(buf_addr_o);

  txd_engine uut (.*);

  typedef struct {
    logic v; logic [7:0] d; logic l; logic n;
    logic e; logic o; logic u; logic on; logic b;
    string req;
  } exp_t;

  exp_t expq[$];
  logic [31:0] mm [WORDS];
  int m_cur = 0;
  logic m_txon = 0, m_in_pkt = 0, m_nocrc = 0;
  int nvec = 0, nfail = 0;

  function automatic exp_t mk(logic v, logic [7:0] d, logic l, logic n, logic e,
                              logic o, logic u, logic on, logic b, string r);
    exp_t x;
    x.v = v; x.d = d; x.l = l; x.n = n; x.e = e; x.o = o; x.u = u; x.on = on; x.b = b; x.req = r;
    return x;
  endfunction

  task automatic tick();
    exp_t x;
    logic bad;
    @(negedge clk_i);
    if (expq.size() > 0) x = expq.pop_front();
    else x = mk(0, 8'h00, 0, 0, 0, 0, 0, m_txon, 0, "R1");
    bad = (tx_valid_o !== x.v) || (tx_last_o !== x.l) || (eop_done_o !== x.e) ||
          (txok_irq_o !== x.o) || (udf_irq_o !== x.u) || (tx_on_o !== x.on) || (busy_o !== x.b);
    if (x.v && ((tx_data_o !== x.d) || (tx_nocrc_o !== x.n))) bad = 1;
    nvec++;
    if (bad) begin
      nfail++;
      $display("FAIL %s t=%0t actual v%b d%02h l%b n%b e%b o%b u%b on%b b%b expected v%b d%02h l%b n%b e%b o%b u%b on%b b%b",
               x.req, $time, tx_valid_o, tx_data_o, tx_last_o, tx_nocrc_o, eop_done_o, txok_irq_o,
               udf_irq_o, tx_on_o, busy_o, x.v, x.d, x.l, x.n, x.e, x.o, x.u, x.on, x.b);
    end
  endtask

  task automatic chk_word(int a, string r);
    host_addr_i = AW'(a);
    #1;
    nvec++;
    if (host_rdata_o !== mm[a]) begin
      nfail++;
      $display("FAIL %s word %0d actual %08h expected %08h", r, a, host_rdata_o, mm[a]);
    end
  endtask

  task automatic host_wr(int a, logic [31:0] d);
    host_we_i = 1; host_addr_i = AW'(a); host_wdata_i = d; mm[a] = d;
    tick();
    host_we_i = 0;
  endtask

  task automatic put_desc(int base, logic [31:0] st, logic [31:0] ct, logic [31:0] ba, logic [31:0] br);
    host_wr(base, st); host_wr(base + 1, ct); host_wr(base + 2, ba); host_wr(base + 3, br);
  endtask

  task automatic set_cur(int a);
    cur_we_i = 1; cur_addr_i = AW'(a); m_cur = a;
    tick();
    cur_we_i = 0;
  endtask

  // behavioural model: expand one poll into per-cycle expectations
  task automatic gen();
    logic [31:0] st, ct, ba, br, sw;
    logic inv, eop, abortc, anyerr;
    int sz;
    m_txon = 1;
    forever begin
      st = mm[m_cur]; ct = mm[m_cur + 1]; ba = mm[m_cur + 2]; br = mm[m_cur + 3];
      expq.push_back(mk(0, 0, 0, 0, 0, 0, 0, 1, 1, st[31] ? "R2" : "R3"));
      if (!st[31]) break;
      eop = ct[22];
      sz = int'(ct[10:0]);
      inv = !m_in_pkt && !ct[21];
      if (ct[21]) m_nocrc = ct[16];
      if (!inv)
        for (int i = 0; i < sz; i++) begin
          logic [15:0] a;
          a = ba[15:0] + 16'(i);
          expq.push_back(mk(1, fdata(a), eop && (i == sz - 1), m_nocrc, 0, 0, 0, 1, 1,
                            m_in_pkt ? "R5" : "R4"));
        end
      sw = '0;
      if (inv) sw[12] = 1;
      else begin
        sw[3:0] = col_cnt_i; sw[4] = |col_cnt_i; sw[8] = err_abort_i; sw[15] = err_abort_i;
        sw[9] = err_late_i; sw[10] = err_carrier_i; sw[11] = err_underflow_i; sw[13] = err_sys_i;
      end
      abortc = sw[8] | sw[11] | sw[12];
      anyerr = |sw[15:8];
      expq.push_back(mk(0, 0, 0, 0, eop && !inv, (eop && !inv && !anyerr) || ct[23], sw[11], 1, 1,
                        sz == 0 ? "R13" : "R9"));
      mm[m_cur] = sw;
      if (abortc) begin m_txon = 0; m_in_pkt = 0; break; end
      m_in_pkt = !eop;
      if ((eop || ct[15]) && br[5:0] != 0) m_cur = int'(br[5:0]);
      else break;
    end
  endtask

  task automatic do_poll(int busy_poll_at);
    poll_i = 1; gen(); tick(); poll_i = 0;
    for (int i = 1; expq.size() > 0; i++) begin
      if (i == busy_poll_at) begin poll_i = 1; tick(); poll_i = 0; end  // R12 ignored while busy
      else tick();
    end
    tick();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  endtask

  localparam logic [31:0] OWN = 32'h8000_0000;
  localparam logic [31:0] CHN = 32'h0000_8000, NOCRC = 32'h0001_0000;
  localparam logic [31:0] SOP = 32'h0020_0000, EOP = 32'h0040_0000, IC = 32'h0080_0000;

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL R1 watchdog actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < WORDS; i++) mm[i] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1 reset state and idle quiet
    repeat (3) tick();

    // R2 R4 R6 single descriptor, collision count reported
    col_cnt_i = 4'd2;
    put_desc(4, OWN, SOP | EOP | 32'd5, 32'h0100, 32'd0);
    set_cur(4);
    do_poll(-1);
    chk_word(4, "R6");
    col_cnt_i = 0;

    // R5 R12 chained frame with no-crc flag, poll while busy ignored
    put_desc(8, OWN, SOP | CHN | NOCRC | 32'd3, 32'h0200, 32'd12);
    put_desc(12, OWN, EOP | 32'd4, 32'h0310, 32'd0);
    set_cur(8);
    do_poll(2);
    chk_word(8, "R5"); chk_word(12, "R5");

    // R11 branch to non-owned descriptor, resume there on next poll
    put_desc(16, OWN, SOP | EOP | 32'd2, 32'h0400, 32'd20);
    put_desc(20, 32'h0, SOP | EOP | 32'd3, 32'h0480, 32'd0);
    set_cur(16);
    do_poll(-1);
    chk_word(20, "R11");
    host_wr(20, OWN);
    do_poll(-1);
    chk_word(20, "R11");

    // R3 poll on a non-owned descriptor
    do_poll(-1);

    // R13 R9 zero-length descriptor with interrupt request
    put_desc(24, OWN, SOP | EOP | IC, 32'h0500, 32'd0);
    set_cur(24);
    do_poll(-1);
    chk_word(24, "R13");

    // R6 R9 non-halting errors suppress transmit-ok
    err_late_i = 1; err_carrier_i = 1; err_sys_i = 1; col_cnt_i = 4'd5;
    put_desc(28, OWN, SOP | EOP | 32'd4, 32'h0600, 32'd0);
    set_cur(28);
    do_poll(-1);
    chk_word(28, "R6");
    err_late_i = 0; err_carrier_i = 0; err_sys_i = 0; col_cnt_i = 0;

    // R10 R7 underflow halts; re-arm with rewritten pointer
    err_underflow_i = 1;
    put_desc(32, OWN, SOP | EOP | 32'd3, 32'h0700, 32'd36);
    put_desc(36, OWN, SOP | EOP | 32'd2, 32'h0780, 32'd0);
    set_cur(32);
    do_poll(-1);
    chk_word(32, "R10");
    repeat (2) tick();  // R7 stays off
    err_underflow_i = 0;
    host_wr(32, OWN);
    set_cur(32);
    do_poll(-1);
    chk_word(32, "R7"); chk_word(36, "R7");

    // R8 descriptor without start outside a frame
    put_desc(40, OWN, EOP | 32'd2, 32'h0800, 32'd0);
    set_cur(40);
    do_poll(-1);
    chk_word(40, "R8");
    host_wr(40, OWN); host_wr(41, SOP | EOP | 32'd2);
    set_cur(40);
    do_poll(-1);
    chk_word(40, "R8");

    // R7 abort with interrupt request still raises transmit-ok pulse (R9)
    err_abort_i = 1;
    put_desc(44, OWN, SOP | EOP | IC | 32'd2, 32'h0900, 32'd0);
    set_cur(44);
    do_poll(-1);
    chk_word(44, "R7");
    err_abort_i = 0;
    repeat (2) tick();

    finish_run();
  end
endmodule